// File: doc/BRIEF.md
# Program Flow Control Unit

This block works out the next program counter for a small 8-bit processor core with a 16-bit code space. It also produces the stack byte requests for subroutine entry and exit. The core hands it one decoded flow operation at a time with `start`. The operation comes with its operand bytes, the address of the following instruction, the accumulator, the 16-bit data pointer pair, the carry flag and two compare operands. The block returns a single result, marked by a one-cycle `done`.

Supported targets are in-page jumps and calls, which keep the top five bits of the following-instruction address and take eleven bits from the operation. Full 16-bit jumps and calls, signed 8-bit relative branches, and a computed jump to accumulator plus data pointer are also supported. Conditional branches test the whole accumulator, the carry flag, or an inequality between two compare operands. The compare also returns a new carry. A call writes its two-byte return address to an external stack one byte per cycle. A return reads the address back one byte per cycle in the opposite order.

Every operation takes two working cycles after it is accepted. The result is presented in the third cycle, and the block can accept the next operation in that same cycle.

Top module: `flow_ctrl`

## Requirements
- R1: Operation code 0 (in-page jump) and code 1 (in-page call) give a target made of bits 15..11 of `pc_next`, then bits 2..0 of `opnd_hi`, then all of `opnd_lo`. The upper five bits of `opnd_hi` are ignored.
- R2: Operation code 2 (far jump) and code 3 (far call) give the target `{opnd_hi, opnd_lo}`.
- R3: Operation code 4 (relative jump) gives `pc_next` plus `opnd_lo` read as a two's-complement byte, modulo 65536.
- R4: Operation code 5 (computed jump) gives `acc + {ptr_hi, ptr_lo}` modulo 65536.
- R5: For codes 1 and 3, `push_req` is high in the first and second cycles after acceptance. `push_byte` carries `pc_next[7:0]` in the first of those cycles and `pc_next[15:8]` in the second.
- R6: For code 6 (return), `pop_req` is high in the first and second cycles after acceptance. The byte on `pop_byte` at the end of the first cycle becomes the result's high byte. The byte at the end of the second cycle becomes its low byte. `push_req` and `pop_req` are never high together.
- R7: Code 7 (interrupt return) pops like code 6. It also raises `irq_done` for exactly the `done` cycle. No other code raises `irq_done`.
- R8: Code 8 branches as in R3 when `acc` is zero. Code 9 branches when `acc` is nonzero. A branch not taken gives `pc_next`.
- R9: Code 10 branches as in R3 when `carry_in` is 1. Code 11 branches when `carry_in` is 0. A branch not taken gives `pc_next`.
- R10: Code 12 branches as in R3 only when `cmp_a` differs from `cmp_b`. It raises `carry_wr` in the `done` cycle with `carry_out` equal to 1 when `cmp_a` is unsigned-less-than `cmp_b`, and 0 otherwise. No other code raises `carry_wr`.
- R11: An operation accepted at a clock edge raises `done` for one cycle, three cycles after that edge. `pc_out` changes only together with `done` and holds until the next `done`.
- R12: A `start` seen while an operation is in progress is ignored. It produces no push, no pop and no extra `done`.
- R13: After reset, `done`, `push_req`, `pop_req`, `carry_wr` and `irq_done` are low, and `pc_out` is zero.
- R14: Codes 13 to 15 give `pc_next` with no push, no pop, no carry write and no interrupt-done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept an operation when idle |
| op_class | input | 4 | Flow operation code |
| opnd_hi | input | 8 | High operand byte (page bits or high target byte) |
| opnd_lo | input | 8 | Low operand byte or relative offset |
| pc_next | input | 16 | Address of the following instruction |
| acc | input | 8 | Accumulator |
| ptr_lo | input | 8 | Data pointer low byte |
| ptr_hi | input | 8 | Data pointer high byte |
| carry_in | input | 1 | Current carry flag |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| pop_byte | input | 8 | Byte read from the stack |
| done | output | 1 | One-cycle result strobe |
| pc_out | output | 16 | Computed next program counter |
| carry_out | output | 1 | Carry produced by compare |
| carry_wr | output | 1 | Carry update strobe |
| push_req | output | 1 | Stack write request |
| push_byte | output | 8 | Byte to write to the stack |
| pop_req | output | 1 | Stack read request |
| irq_done | output | 1 | Interrupt service finished |

## Verification
The result strobe of one operation and the acceptance of the next can fall in the same cycle, because the sequencer returns to idle while `done` is high. The bench provokes this by raising the next `start` in the very cycle it observes `done`, through the whole vector table and the call/return sequences. Each following operation must then show its pushes or pops in the next two cycles, while the earlier `pc_out` is still held. A second overlap, a `start` arriving during the two working cycles, is driven with a call code and judged by the absence of any push and of a second `done`.

// File: rtl/flow_pkg.sv
package flow_pkg;

   typedef enum logic [3:0] {
      OP_PAGE_JMP   = 4'd0,
      OP_PAGE_CALL  = 4'd1,
      OP_FAR_JMP    = 4'd2,
      OP_FAR_CALL   = 4'd3,
      OP_REL_JMP    = 4'd4,
      OP_PTR_JMP    = 4'd5,
      OP_RETURN     = 4'd6,
      OP_IRQ_RETURN = 4'd7,
      OP_IF_ZERO    = 4'd8,
      OP_IF_NONZERO = 4'd9,
      OP_IF_CARRY   = 4'd10,
      OP_IF_NOCARRY = 4'd11,
      OP_CMP_NE     = 4'd12
   } flow_op_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_SECOND = 2'd2
   } flow_phase_e;

   function automatic logic op_is_call(input logic [3:0] op);
      return (op == OP_PAGE_CALL) || (op == OP_FAR_CALL);
   endfunction

   function automatic logic op_is_return(input logic [3:0] op);
      return (op == OP_RETURN) || (op == OP_IRQ_RETURN);
   endfunction

endpackage

// File: rtl/flow_target_calc.sv
module flow_target_calc #(
   parameter int PC_W   = 16,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 11
) (
   input  logic [PC_W-1:0]   pc_base,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] ptr_lo,
   input  logic [DATA_W-1:0] ptr_hi,
   output logic [PC_W-1:0]   page_tgt,
   output logic [PC_W-1:0]   far_tgt,
   output logic [PC_W-1:0]   rel_tgt,
   output logic [PC_W-1:0]   ptr_tgt
);
   localparam int SEL_W = PAGE_W - DATA_W;
   localparam int EXT_W = PC_W - DATA_W;

   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] acc_ext;

   generate
      if (PAGE_W < PC_W) begin : g_paged
         assign page_tgt = {pc_base[PC_W-1:PAGE_W], opnd_hi[SEL_W-1:0], opnd_lo};
      end else begin : g_flat
         assign page_tgt = {opnd_hi[SEL_W-1:0], opnd_lo};
      end
   endgenerate

   assign far_tgt = {opnd_hi, opnd_lo};
   assign off_ext = {{EXT_W{opnd_lo[DATA_W-1]}}, opnd_lo};
   assign rel_tgt = pc_base + off_ext;
   assign acc_ext = {{EXT_W{1'b0}}, acc};
   assign ptr_tgt = {ptr_hi, ptr_lo} + acc_ext;

endmodule

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
   import flow_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] acc,
   input  logic              carry,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   output logic              taken,
   output logic              cy_wr,
   output logic              cy_res
);
   logic acc_zero;

   assign acc_zero = (acc == '0);

   always_comb begin
      case (op)
         OP_IF_ZERO:    taken = acc_zero;
         OP_IF_NONZERO: taken = !acc_zero;
         OP_IF_CARRY:   taken = carry;
         OP_IF_NOCARRY: taken = !carry;
         OP_CMP_NE:     taken = (cmp_a != cmp_b);
         default:       taken = 1'b0;
      endcase
   end

   assign cy_wr  = (op == OP_CMP_NE);
   assign cy_res = (cmp_a < cmp_b);

endmodule

// File: rtl/flow_stack_seq.sv
module flow_stack_seq #(
   parameter int PC_W   = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first,
   input  logic              second,
   input  logic              is_call,
   input  logic              is_ret,
   input  logic [PC_W-1:0]   pc_base,
   input  logic [DATA_W-1:0] pop_byte,
   output logic              push_req,
   output logic [DATA_W-1:0] push_byte,
   output logic              pop_req,
   output logic [PC_W-1:0]   ret_addr
);
   logic [DATA_W-1:0] hi_r;

   assign push_req  = is_call && (first || second);
   assign pop_req   = is_ret  && (first || second);
   assign push_byte = !push_req ? '0 :
                      first     ? pc_base[DATA_W-1:0] : pc_base[PC_W-1:DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_r <= '0;
      else if (first && is_ret)
         hi_r <= pop_byte;
   end

   assign ret_addr = {hi_r, pop_byte};

endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
   import flow_pkg::*;
#(
   parameter int PC_W   = 16,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        op_class,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [PC_W-1:0]   pc_next,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] ptr_lo,
   input  logic [DATA_W-1:0] ptr_hi,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   input  logic [DATA_W-1:0] pop_byte,
   output logic              done,
   output logic [PC_W-1:0]   pc_out,
   output logic              carry_out,
   output logic              carry_wr,
   output logic              push_req,
   output logic [DATA_W-1:0] push_byte,
   output logic              pop_req,
   output logic              irq_done
);
   generate
      if (PC_W != 2 * DATA_W) begin : g_bad_width
         $error("flow_ctrl: PC_W must equal twice DATA_W");
      end
      if (PAGE_W <= DATA_W || PAGE_W > PC_W) begin : g_bad_page
         $error("flow_ctrl: PAGE_W must lie above DATA_W and not exceed PC_W");
      end
   endgenerate

   flow_phase_e       phase;
   logic [3:0]        op_q;
   logic [DATA_W-1:0] hi_q, lo_q, acc_q, plo_q, phi_q, ca_q, cb_q;
   logic [PC_W-1:0]   pcb_q;
   logic              cy_q;
   logic              accept;

   assign accept = start && (phase == PH_IDLE);

   // operand capture on acceptance
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
         pcb_q <= '0;
         acc_q <= '0;
         plo_q <= '0;
         phi_q <= '0;
         cy_q  <= 1'b0;
         ca_q  <= '0;
         cb_q  <= '0;
      end else if (accept) begin
         op_q  <= op_class;
         hi_q  <= opnd_hi;
         lo_q  <= opnd_lo;
         pcb_q <= pc_next;
         acc_q <= acc;
         plo_q <= ptr_lo;
         phi_q <= ptr_hi;
         cy_q  <= carry_in;
         ca_q  <= cmp_a;
         cb_q  <= cmp_b;
      end
   end

   logic [PC_W-1:0] page_tgt, far_tgt, rel_tgt, ptr_tgt, ret_addr;
   logic            taken, cy_wr, cy_res;

   flow_target_calc #(.PC_W(PC_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_tgt (
      .pc_base  (pcb_q),
      .opnd_hi  (hi_q),
      .opnd_lo  (lo_q),
      .acc      (acc_q),
      .ptr_lo   (plo_q),
      .ptr_hi   (phi_q),
      .page_tgt (page_tgt),
      .far_tgt  (far_tgt),
      .rel_tgt  (rel_tgt),
      .ptr_tgt  (ptr_tgt)
   );

   flow_cond_eval #(.DATA_W(DATA_W)) u_cond (
      .op     (op_q),
      .acc    (acc_q),
      .carry  (cy_q),
      .cmp_a  (ca_q),
      .cmp_b  (cb_q),
      .taken  (taken),
      .cy_wr  (cy_wr),
      .cy_res (cy_res)
   );

   flow_stack_seq #(.PC_W(PC_W), .DATA_W(DATA_W)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .first     (phase == PH_FIRST),
      .second    (phase == PH_SECOND),
      .is_call   (op_is_call(op_q)),
      .is_ret    (op_is_return(op_q)),
      .pc_base   (pcb_q),
      .pop_byte  (pop_byte),
      .push_req  (push_req),
      .push_byte (push_byte),
      .pop_req   (pop_req),
      .ret_addr  (ret_addr)
   );

   logic [PC_W-1:0] next_pc;

   always_comb begin
      case (op_q)
         OP_PAGE_JMP, OP_PAGE_CALL: next_pc = page_tgt;
         OP_FAR_JMP, OP_FAR_CALL:   next_pc = far_tgt;
         OP_REL_JMP:                next_pc = rel_tgt;
         OP_PTR_JMP:                next_pc = ptr_tgt;
         OP_RETURN, OP_IRQ_RETURN:  next_pc = ret_addr;
         OP_IF_ZERO, OP_IF_NONZERO,
         OP_IF_CARRY, OP_IF_NOCARRY,
         OP_CMP_NE:                 next_pc = taken ? rel_tgt : pcb_q;
         default:                   next_pc = pcb_q;
      endcase
   end

   // sequencing and registered result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         done      <= 1'b0;
         pc_out    <= '0;
         carry_out <= 1'b0;
         carry_wr  <= 1'b0;
         irq_done  <= 1'b0;
      end else begin
         done     <= 1'b0;
         carry_wr <= 1'b0;
         irq_done <= 1'b0;
         case (phase)
            PH_IDLE:  if (start) phase <= PH_FIRST;
            PH_FIRST: phase <= PH_SECOND;
            PH_SECOND: begin
               phase    <= PH_IDLE;
               done     <= 1'b1;
               pc_out   <= next_pc;
               carry_wr <= cy_wr;
               if (cy_wr) carry_out <= cy_res;
               irq_done <= (op_q == OP_IRQ_RETURN);
            end
            default:  phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            done,
   input logic [PC_W-1:0] pc_out,
   input logic            carry_wr,
   input logic            push_req,
   input logic            pop_req,
   input logic            irq_done
);
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(pc_out));

   assert_push_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(push_req) |=> push_req);

   assert_pop_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pop_req) |=> pop_req);

   assert_stack_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_req && pop_req));

   assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |-> done);

   assert_carry_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      carry_wr |-> done);

endmodule

bind flow_ctrl flow_ctrl_chk #(.PC_W(PC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .pc_out   (pc_out),
   .carry_wr (carry_wr),
   .push_req (push_req),
   .pop_req  (pop_req),
   .irq_done (irq_done)
);

// File: tb/flow_ctrl_test.sv
module flow_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op_class = '0;
   logic [7:0]  opnd_hi = '0, opnd_lo = '0, acc = '0, ptr_lo = '0, ptr_hi = '0;
   logic [15:0] pc_next = '0;
   logic        carry_in = 1'b0;
   logic [7:0]  cmp_a = '0, cmp_b = '0, pop_byte = '0;
   logic        done, carry_out, carry_wr, push_req, pop_req, irq_done;
   logic [15:0] pc_out;
   logic [7:0]  push_byte;

   always #5 clk = ~clk;

   flow_ctrl uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
      .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .pc_next(pc_next), .acc(acc),
      .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .carry_in(carry_in),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .pop_byte(pop_byte),
      .done(done), .pc_out(pc_out), .carry_out(carry_out), .carry_wr(carry_wr),
      .push_req(push_req), .push_byte(push_byte), .pop_req(pop_req),
      .irq_done(irq_done)
   );

   int nchk = 0;
   int nbad = 0;
   bit finished = 1'b0;
   logic [15:0] last_pc = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [3:0]  op;
      logic [7:0]  hi;
      logic [7:0]  lo;
      logic [15:0] pcn;
      logic [7:0]  acc;
      logic [7:0]  plo;
      logic [7:0]  phi;
      logic        cy;
      logic [7:0]  ca;
      logic [7:0]  cb;
      logic [15:0] epc;
      logic        ecy;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{4'd0,  8'h05, 8'h3C, 16'hA7F2, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'hA53C, 1'b0}, // R1
      '{4'd0,  8'hFF, 8'hFF, 16'h07FF, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h07FF, 1'b0}, // R1
      '{4'd0,  8'h00, 8'h00, 16'hFFFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'hF800, 1'b0}, // R1
      '{4'd2,  8'h12, 8'h34, 16'h9999, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h1234, 1'b0}, // R2
      '{4'd4,  8'h00, 8'h80, 16'h0100, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h0080, 1'b0}, // R3
      '{4'd4,  8'h00, 8'h7F, 16'hFFF0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h006F, 1'b0}, // R3
      '{4'd4,  8'h00, 8'hFF, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'hFFFF, 1'b0}, // R3
      '{4'd5,  8'h00, 8'h00, 16'h4444, 8'hFF, 8'hFF, 8'hFF, 1'b0, 8'h00, 8'h00, 16'h00FE, 1'b0}, // R4
      '{4'd5,  8'h00, 8'h00, 16'h4444, 8'h10, 8'hF8, 8'h12, 1'b0, 8'h00, 8'h00, 16'h1308, 1'b0}, // R4
      '{4'd8,  8'h00, 8'h04, 16'h2000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h2004, 1'b0}, // R8
      '{4'd8,  8'h00, 8'h04, 16'h2000, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h2000, 1'b0}, // R8
      '{4'd9,  8'h00, 8'hFE, 16'h2000, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h1FFE, 1'b0}, // R8
      '{4'd9,  8'h00, 8'hFE, 16'h2000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h2000, 1'b0}, // R8
      '{4'd10, 8'h00, 8'h10, 16'h3000, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 8'h00, 16'h3010, 1'b0}, // R9
      '{4'd10, 8'h00, 8'h10, 16'h3000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h3000, 1'b0}, // R9
      '{4'd11, 8'h00, 8'h10, 16'h3000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h3010, 1'b0}, // R9
      '{4'd11, 8'h00, 8'h10, 16'h3000, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 8'h00, 16'h3000, 1'b0}, // R9
      '{4'd12, 8'h00, 8'h20, 16'h4000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h03, 8'h09, 16'h4020, 1'b1}, // R10
      '{4'd12, 8'h00, 8'h20, 16'h4000, 8'h00, 8'h00, 8'h00, 1'b1, 8'h09, 8'h03, 16'h4020, 1'b0}, // R10
      '{4'd12, 8'h00, 8'h20, 16'h4000, 8'h00, 8'h00, 8'h00, 1'b1, 8'h55, 8'h55, 16'h4000, 1'b0}, // R10
      '{4'd12, 8'h00, 8'h20, 16'h4000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h80, 8'h7F, 16'h4020, 1'b0}, // R10
      '{4'd14, 8'hAA, 8'h55, 16'h5555, 8'h00, 8'h00, 8'h00, 1'b1, 8'h01, 8'h02, 16'h5555, 1'b0}  // R14
   };

   // Starts at a negedge, returns at the negedge of the done cycle.
   task automatic run_op(input vec_t v, input logic [7:0] p1, input logic [7:0] p2,
                         input bit epush, input logic [7:0] eb1, input logic [7:0] eb2,
                         input bit epop, input bit eirq, input string req);
      op_class = v.op; opnd_hi = v.hi; opnd_lo = v.lo; pc_next = v.pcn;
      acc = v.acc; ptr_lo = v.plo; ptr_hi = v.phi; carry_in = v.cy;
      cmp_a = v.ca; cmp_b = v.cb; pop_byte = p1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R11 no done in first cycle", done, 0);
      chk(pc_out == last_pc, "R11 pc held", pc_out, last_pc);
      chk(push_req == epush, {req, " push first"}, push_req, epush);
      if (epush) chk(push_byte == eb1, "R5 low byte first", push_byte, eb1);
      chk(pop_req == epop, {req, " pop first"}, pop_req, epop);
      @(negedge clk);
      pop_byte = p2;
      chk(done == 1'b0, "R11 no done in second cycle", done, 0);
      chk(push_req == epush, {req, " push second"}, push_req, epush);
      if (epush) chk(push_byte == eb2, "R5 high byte second", push_byte, eb2);
      chk(pop_req == epop, {req, " pop second"}, pop_req, epop);
      @(negedge clk);
      chk(done == 1'b1, "R11 done in third cycle", done, 1);
      chk(pc_out == v.epc, {req, " target"}, pc_out, v.epc);
      chk(carry_wr == (v.op == 4'd12), "R10 carry_wr only for compare", carry_wr, (v.op == 4'd12));
      if (v.op == 4'd12) chk(carry_out == v.ecy, "R10 carry result", carry_out, v.ecy);
      chk(irq_done == eirq, "R7 irq_done", irq_done, eirq);
      chk(push_req == 1'b0 && pop_req == 1'b0, "R6 stack idle at done",
          {push_req, pop_req}, 0);
      last_pc = v.epc;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nbad++;
         $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(done == 1'b0, "R13 done low", done, 0);
      chk(pc_out == 16'h0, "R13 pc_out zero", pc_out, 0);
      chk(push_req == 1'b0 && pop_req == 1'b0, "R13 stack idle", {push_req, pop_req}, 0);
      chk(carry_wr == 1'b0 && irq_done == 1'b0, "R13 strobes low", {carry_wr, irq_done}, 0);

      // vector table, each start raised in the previous done cycle
      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i], 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R1-table");
      end

      // R1 in-page call with pushes (R5)
      v = '{4'd1, 8'h03, 8'h21, 16'h8A46, 8'h0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0, 16'h8B21, 1'b0};
      run_op(v, 8'h00, 8'h00, 1'b1, 8'h46, 8'h8A, 1'b0, 1'b0, "R5 page call");
      // R2 far call with pushes (R5)
      v = '{4'd3, 8'hBE, 8'hEF, 16'h1234, 8'h0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0, 16'hBEEF, 1'b0};
      run_op(v, 8'h00, 8'h00, 1'b1, 8'h34, 8'h12, 1'b0, 1'b0, "R5 far call");
      // R6 return: first pop is high byte
      v = '{4'd6, 8'h0, 8'h0, 16'h7777, 8'h0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0, 16'hC35A, 1'b0};
      run_op(v, 8'hC3, 8'h5A, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R6 return");
      // R7 interrupt return
      v = '{4'd7, 8'h0, 8'h0, 16'h7777, 8'h0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0, 16'h0102, 1'b0};
      run_op(v, 8'h01, 8'h02, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, "R7 irq return");

      // R12 start held high during the working cycles
      op_class = 4'd2; opnd_hi = 8'h11; opnd_lo = 8'h11; start = 1'b1;
      @(negedge clk);
      op_class = 4'd3; opnd_hi = 8'h22; opnd_lo = 8'h22; pc_next = 16'h3344;
      chk(push_req == 1'b0, "R12 no push while busy", push_req, 0);
      @(negedge clk);
      chk(push_req == 1'b0, "R12 no push while busy", push_req, 0);
      start = 1'b0;
      @(negedge clk);
      chk(done == 1'b1 && pc_out == 16'h1111, "R12 first result kept", pc_out, 16'h1111);
      @(negedge clk);
      chk(done == 1'b0, "R12 no second done", done, 0);
      chk(push_req == 1'b0, "R12 ignored call not pushed", push_req, 0);
      @(negedge clk);
      chk(done == 1'b0 && pc_out == 16'h1111, "R11 result held", pc_out, 16'h1111);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule